// File: doc/BRIEF.md
# Coherent Double-Byte PWM Register Loader

This block holds the 16-bit period (modulus) register and one 16-bit compare value register per channel of a PWM timer. Software reaches them through an 8-bit bus. Each byte write lands in a shadow buffer that belongs to one register. A buffered value moves into the active register only after both of its bytes have been written. For the modulus and for channels in PWM mode, the move also waits for the period-end pulse from the timer counter. A channel in output-compare mode moves its value as soon as the pair is complete.

Each register tracks separately whether its upper byte and its lower byte have been written. Bytes may arrive in either order. A pulse on a control-register write strobe throws away a half-finished update: the main strobe acts on the modulus and each channel strobe acts on its own channel. The counter and the compare logic sit outside this block. They take the active values from its outputs.

Top module: `pwm_shadow_loader`

## Requirements
- R1: A byte write changes only the shadow buffer. An active output changes only on the clock edge that moves a complete buffered pair into it. `wr_tgt` = 0 selects the modulus and `wr_tgt` = k selects channel k-1. A target above NUM_CH is ignored.
- R2: A move happens only after both bytes of the register have been written, in either order. `wr_hi` = 1 writes bits 15:8 and `wr_hi` = 0 writes bits 7:0.
- R3: Writing the same byte again replaces its buffered value but does not complete the pair.
- R4: The modulus, and every channel whose `ch_oc_mode` bit is 0, move a complete pair on the edge where `period_end` is 1. A pair completed by a write on that same edge waits for the next `period_end`.
- R5: A channel whose `ch_oc_mode` bit is 1 moves its pair on the clock edge after the pair completes, without `period_end`.
- R6: Any number of registers loaded during one period all become active on the same `period_end` edge.
- R7: A `ctl_wr_main` pulse clears both written flags of the modulus. Bytes written before the pulse then no longer count toward a pair. If it coincides with a move, the move is dropped.
- R8: A pulse on bit k of `ctl_wr_ch` clears the written flags of channel k only. Other registers are unaffected.
- R9: After a move both written flags are clear, so the next update again needs both bytes.
- R10: After reset the modulus and all channel values read 0x0000 and no update is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | 1: upper byte, 0: lower byte |
| wr_tgt | input | $clog2(NUM_CH+1) | 0: modulus, k: channel k-1 |
| wr_data | input | 8 | Byte to write |
| ctl_wr_main | input | 1 | Main control register written (cancels modulus update) |
| ctl_wr_ch | input | NUM_CH | Channel control register written, one bit per channel |
| period_end | input | 1 | Counter overflow / direction reversal pulse |
| ch_oc_mode | input | NUM_CH | 1: channel in output-compare mode |
| mod_active | output | 16 | Active modulus |
| ch_active | output | 16*NUM_CH | Active channel values, channel k at bits 16k+15:16k |

## Verification
The hardest state to reach is a half-finished pair: one byte is flagged and the other byte's buffer still holds a stale value from before a cancel. Only that state shows whether a cancel drops the flags and keeps stale bytes out of the next pair. The bench writes an upper byte, pulses the control strobe, and then writes the lower byte. It pulses `period_end` to show that nothing moves, then writes a new upper byte and checks the exact value that moves. A second hard case is a pair completed on the same edge as `period_end`. The bench drives the final byte and the period pulse together and checks that the move waits one period.

// File: rtl/pwm_ld_pkg.sv
package pwm_ld_pkg;

  parameter int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  // Per-slot control strobes produced by the write decoder
  typedef struct packed {
    logic wr_upper;
    logic wr_lower;
    logic cancel;
  } slot_ctl_t;

endpackage

// File: rtl/pwm_ld_rst_sync.sv
module pwm_ld_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_ld_decode.sv
module pwm_ld_decode
  import pwm_ld_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned NSLOT = NUM_CH + 1,
  localparam int unsigned TGT_W = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_hi,
  input  logic [TGT_W-1:0]       wr_tgt,
  input  logic                   ctl_wr_main,
  input  logic [NUM_CH-1:0]      ctl_wr_ch,
  output slot_ctl_t [NSLOT-1:0]  slot_ctl
);

  logic [NSLOT-1:0] upper_vec;
  logic [NSLOT-1:0] lower_vec;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      slot_ctl[s].wr_upper = wr_en && wr_hi  && (32'(wr_tgt) == s);
      slot_ctl[s].wr_lower = wr_en && !wr_hi && (32'(wr_tgt) == s);
      slot_ctl[s].cancel   = (s == 0) ? ctl_wr_main : ctl_wr_ch[(s == 0) ? 0 : s-1];
      upper_vec[s] = slot_ctl[s].wr_upper;
      lower_vec[s] = slot_ctl[s].wr_lower;
    end
  end

  // R1: a single byte write reaches at most one buffer half
  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({upper_vec, lower_vec}) <= 1);

  // R1: no buffer strobe without a bus write
  assert_no_spurious_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (upper_vec == '0 && lower_vec == '0));

endmodule

// File: rtl/pwm_ld_slot.sv
module pwm_ld_slot
  import pwm_ld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  slot_ctl_t         ctl,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              immediate,
  input  logic              period_end,
  output logic [WORD_W-1:0] act_o
);

  logic [WORD_W-1:0] shadow_q, shadow_d;
  logic [WORD_W-1:0] act_q, act_d;
  logic              upper_ok_q, upper_ok_d;
  logic              lower_ok_q, lower_ok_d;
  logic              pair_ready;
  logic              move;
  logic              shadow_en, act_en, flag_en;

  assign pair_ready = upper_ok_q && lower_ok_q;
  assign move       = pair_ready && (immediate || period_end) && !ctl.cancel;

  // Next-state logic
  always_comb begin
    shadow_d   = shadow_q;
    act_d      = act_q;
    upper_ok_d = upper_ok_q;
    lower_ok_d = lower_ok_q;
    if (move) begin
      act_d      = shadow_q;
      upper_ok_d = 1'b0;
      lower_ok_d = 1'b0;
    end
    if (ctl.cancel) begin
      upper_ok_d = 1'b0;
      lower_ok_d = 1'b0;
    end
    if (ctl.wr_upper) begin
      shadow_d[WORD_W-1:BYTE_W] = wdata;
      upper_ok_d                = !ctl.cancel;
    end
    if (ctl.wr_lower) begin
      shadow_d[BYTE_W-1:0] = wdata;
      lower_ok_d           = !ctl.cancel;
    end
  end

  assign shadow_en = ctl.wr_upper || ctl.wr_lower;
  assign act_en    = move;
  assign flag_en   = move || ctl.cancel || shadow_en;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      act_q      <= '0;
      upper_ok_q <= 1'b0;
      lower_ok_q <= 1'b0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (act_en)    act_q    <= act_d;
      if (flag_en) begin
        upper_ok_q <= upper_ok_d;
        lower_ok_q <= lower_ok_d;
      end
    end
  end

  assign act_o = act_q;

  // R2: without both bytes flagged the active value holds
  assert_hold_until_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(upper_ok_q && lower_ok_q) |=> $stable(act_q));

  // R4: a buffered register holds between period ends
  assert_wait_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!immediate && !period_end) |=> $stable(act_q));

  // R7/R8: cancel drops pending flags and any move
  assert_cancel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cancel && !ctl.wr_upper && !ctl.wr_lower) |=> (!upper_ok_q && !lower_ok_q && $stable(act_q)));

  // R9: flags are empty after a move when no byte arrived alongside
  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_ok_q && lower_ok_q && (immediate || period_end) && !ctl.wr_upper && !ctl.wr_lower)
      |=> (!upper_ok_q && !lower_ok_q));

  // R9: a completed move loads the buffered word
  assert_move_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_ok_q && lower_ok_q && (immediate || period_end) && !ctl.cancel)
      |=> (act_q == $past(shadow_q)));

endmodule

// File: rtl/pwm_shadow_loader.sv
module pwm_shadow_loader
  import pwm_ld_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned NSLOT = NUM_CH + 1,
  localparam int unsigned TGT_W = $clog2(NSLOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_hi,
  input  logic [TGT_W-1:0]         wr_tgt,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic                     ctl_wr_main,
  input  logic [NUM_CH-1:0]        ctl_wr_ch,
  input  logic                     period_end,
  input  logic [NUM_CH-1:0]        ch_oc_mode,
  output logic [WORD_W-1:0]        mod_active,
  output logic [NUM_CH*WORD_W-1:0] ch_active
);

  logic                   rst_n_int;
  slot_ctl_t [NSLOT-1:0]  slot_ctl;
  logic [NSLOT-1:0]       slot_imm;
  logic [WORD_W-1:0]      slot_act [NSLOT];

  pwm_ld_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pwm_ld_decode #(.NUM_CH(NUM_CH)) i_decode (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .wr_en       (wr_en),
    .wr_hi       (wr_hi),
    .wr_tgt      (wr_tgt),
    .ctl_wr_main (ctl_wr_main),
    .ctl_wr_ch   (ctl_wr_ch),
    .slot_ctl    (slot_ctl)
  );

  // Slot 0 (modulus) always waits for the period end
  assign slot_imm = {ch_oc_mode, 1'b0};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    pwm_ld_slot i_slot (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .ctl        (slot_ctl[s]),
      .wdata      (wr_data),
      .immediate  (slot_imm[s]),
      .period_end (period_end),
      .act_o      (slot_act[s])
    );
  end

  assign mod_active = slot_act[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    assign ch_active[c*WORD_W +: WORD_W] = slot_act[c+1];
  end

  // R6: with no period end, buffered (non-immediate) registers hold together
  assert_modulus_sync_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    !period_end |=> $stable(mod_active));

endmodule

// File: tb/test_pwm_shadow_loader.sv
module test_pwm_shadow_loader;

  localparam int NUM_CH = 4;
  localparam int TGT_W  = $clog2(NUM_CH + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                wr_en = 1'b0;
  logic                wr_hi = 1'b0;
  logic [TGT_W-1:0]    wr_tgt = '0;
  logic [7:0]          wr_data = '0;
  logic                ctl_wr_main = 1'b0;
  logic [NUM_CH-1:0]   ctl_wr_ch = '0;
  logic                period_end = 1'b0;
  logic [NUM_CH-1:0]   ch_oc_mode = '0;
  logic [15:0]         mod_active;
  logic [NUM_CH*16-1:0] ch_active;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pwm_shadow_loader #(.NUM_CH(NUM_CH)) i_pwm_shadow_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_tgt(wr_tgt),
    .wr_data(wr_data), .ctl_wr_main(ctl_wr_main), .ctl_wr_ch(ctl_wr_ch),
    .period_end(period_end), .ch_oc_mode(ch_oc_mode),
    .mod_active(mod_active), .ch_active(ch_active)
  );

  function automatic logic [15:0] chv(int k);
    return ch_active[k*16 +: 16];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One byte write, optionally with period_end on the same edge
  task automatic wr_byte(int tgt, bit hi, logic [7:0] d, bit pe = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_tgt = TGT_W'(tgt); wr_data = d; period_end = pe;
    @(negedge clk);
    wr_en = 1'b0; period_end = 1'b0;
  endtask

  task automatic pulse_pe();
    @(negedge clk); period_end = 1'b1;
    @(negedge clk); period_end = 1'b0;
  endtask

  task automatic pulse_main();
    @(negedge clk); ctl_wr_main = 1'b1;
    @(negedge clk); ctl_wr_main = 1'b0;
  endtask

  task automatic pulse_ch(int k);
    @(negedge clk); ctl_wr_ch[k] = 1'b1;
    @(negedge clk); ctl_wr_ch = '0;
  endtask

  task automatic t_reset();
    check("R10 modulus", mod_active, 16'h0000);
    for (int k = 0; k < NUM_CH; k++) check("R10 channel", chv(k), 16'h0000);
    pulse_pe();
    check("R10 nothing pending", mod_active, 16'h0000);
    check("R10 nothing pending ch0", chv(0), 16'h0000);
  endtask

  task automatic t_pwm_basic();
    wr_byte(1, 1'b0, 8'h34);
    wr_byte(1, 1'b1, 8'h12);
    repeat (3) @(negedge clk);
    check("R1 buffer only", chv(0), 16'h0000);
    pulse_pe();
    check("R4 pwm move on period end", chv(0), 16'h1234);
    wr_byte(0, 1'b1, 8'hAB);
    wr_byte(0, 1'b0, 8'hCD);
    check("R1 modulus buffered", mod_active, 16'h0000);
    pulse_pe();
    check("R4 modulus move", mod_active, 16'hABCD);
  endtask

  task automatic t_order_rewrite();
    wr_byte(2, 1'b1, 8'h55);
    pulse_pe();
    check("R2 single byte no move", chv(1), 16'h0000);
    wr_byte(2, 1'b1, 8'h66);
    pulse_pe();
    check("R3 rewrite no pair", chv(1), 16'h0000);
    wr_byte(2, 1'b0, 8'h77);
    pulse_pe();
    check("R2 upper then lower", chv(1), 16'h6677);
    wr_byte(3, 1'b1, 8'h11);
    wr_byte(3, 1'b0, 8'h22, 1'b1);
    check("R4 pair on period edge waits", chv(2), 16'h0000);
    pulse_pe();
    check("R4 next period moves", chv(2), 16'h1122);
  endtask

  task automatic t_oc();
    ch_oc_mode[3] = 1'b1;
    wr_byte(4, 1'b0, 8'hBC);
    wr_byte(4, 1'b1, 8'h9A);
    check("R5 not yet on completing edge", chv(3), 16'h0000);
    @(negedge clk);
    check("R5 oc immediate move", chv(3), 16'h9ABC);
  endtask

  task automatic t_multi();
    wr_byte(1, 1'b1, 8'hA1); wr_byte(1, 1'b0, 8'hA2);
    wr_byte(2, 1'b0, 8'hB2); wr_byte(2, 1'b1, 8'hB1);
    wr_byte(3, 1'b1, 8'hC1); wr_byte(3, 1'b0, 8'hC2);
    wr_byte(0, 1'b0, 8'hD2); wr_byte(0, 1'b1, 8'hD1);
    check("R6 ch0 held", chv(0), 16'h1234);
    check("R6 ch2 held", chv(2), 16'h1122);
    pulse_pe();
    check("R6 ch0 together", chv(0), 16'hA1A2);
    check("R6 ch1 together", chv(1), 16'hB1B2);
    check("R6 ch2 together", chv(2), 16'hC1C2);
    check("R6 modulus together", mod_active, 16'hD1D2);
  endtask

  task automatic t_cancel_main();
    wr_byte(0, 1'b1, 8'h01);
    pulse_main();
    wr_byte(0, 1'b0, 8'h02);
    pulse_pe();
    check("R7 cancelled upper not counted", mod_active, 16'hD1D2);
    wr_byte(0, 1'b1, 8'h03);
    pulse_pe();
    check("R7 fresh pair after cancel", mod_active, 16'h0302);
  endtask

  task automatic t_cancel_ch();
    wr_byte(1, 1'b1, 8'hEE); wr_byte(1, 1'b0, 8'hEF);
    wr_byte(2, 1'b1, 8'h44); wr_byte(2, 1'b0, 8'h45);
    pulse_ch(0);
    pulse_pe();
    check("R8 cancelled channel holds", chv(0), 16'hA1A2);
    check("R8 other channel moves", chv(1), 16'h4445);
  endtask

  task automatic t_reneed();
    wr_byte(4, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 one byte after move", chv(3), 16'h9ABC);
    wr_byte(4, 1'b1, 8'h77);
    @(negedge clk);
    check("R9 second pair moves", chv(3), 16'h7700);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pwm_basic();
    t_order_rewrite();
    t_oc();
    t_multi();
    t_cancel_main();
    t_cancel_ch();
    t_reneed();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule